// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Write Access

This block is a watchdog peripheral on a small 32-bit register bus. Software loads two preload values. It enables the watchdog and then has to keep restarting the count. If software stops doing that, the first stage runs out and raises an interrupt. The second stage then starts counting from its own preload. When it runs out, the block pulses a reset request and records a sticky timeout flag. A free-running prescaler produces the count tick. One configuration bit chooses between a slow divide and a fast divide of the input clock.

Three registers are guarded: both preloads and the reload/status register. Software opens them with a two-write key: 0x80 and then 0x86, written to the low byte of the reload register. Each completed key admits exactly one guarded write. A lock bit in the control register stops software from disabling a running watchdog. Only the power-on reset input clears the lock bit and the timeout flag. The block's own reset request does not feed back into it.

Top module: `dual_stage_watchdog`

## Requirements
- R1: Register words sit at byte offsets 0x00 (stage-1 preload, 20 bits), 0x04 (stage-2 preload, 20 bits), 0x08 (bit 0 = latched interrupt), 0x0C (bit 8 = restart command, bit 9 = timeout flag), 0x10 (bit 0 = lock, bit 1 = enable, bit 2 = mode, 0 meaning watchdog) and 0x14 (bits 1:0 = interrupt type, bit 2 = fast tick, bit 5 = reset mask). Byte enables select which bytes a write changes. Every register reads zero after power-on reset.
- R2: A write to 0x00, 0x04 or 0x0C has no effect unless the key is complete. A key write is a write to 0x0C with byte 0 enabled and low byte 0x80 or 0x86. The key is complete only when a 0x86 write directly follows a 0x80 write, with no guarded write in between.
- R3: One completed key admits exactly one guarded write. After that write, further guarded writes are ignored until a new key is given.
- R4: A guarded write to 0x0C with bit 8 set restarts the count at stage 1 from the stage-1 preload. While restarts keep coming, no expiry occurs.
- R5: While enabled, stage 1 expires on the tick that finds its count at zero, that is, after preload+1 ticks. Stage 2 then loads its preload and expires after its own preload+1 ticks. Stage-2 expiry produces a one-cycle reset pulse and returns the count to stage 1.
- R6: Stage-2 expiry in watchdog mode sets bit 9 of 0x0C. The bit is cleared only by a guarded write with bit 9 set, or by power-on reset.
- R7: Once the lock bit is set, the enable bit and the mode bit can no longer be changed by writes: writing 0 reads back still enabled and the count keeps running. Only power-on reset clears the lock.
- R8: With config bit 5 set, stage-2 expiry produces no reset pulse but still sets the timeout flag.
- R9: With interrupt type 11, stage-1 expiry neither latches status nor asserts the interrupt. With any other type, it sets status bit 0 and drives the interrupt output high until a write of 1 to bit 0 of 0x08.
- R10: With config bit 2 clear, a tick occurs every 2^15 clocks. With it set, a tick occurs every 2^5 clocks.
- R11: In timer mode (control bit 2 set), stage-2 expiry produces neither the reset pulse nor the timeout flag.
- R12: While the watchdog is disabled, the count is held at the stage-1 preload and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the prescaler source |
| rstN | input | 1 | Active-low power-on reset |
| busAddr | input | 5 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busBe | input | 4 | Byte enables of the write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Stage-1 interrupt, held until cleared |
| wdtRstOut | output | 1 | One-cycle reset request on stage-2 expiry |

## Verification
The tick phase relative to a bus write cannot be seen from the ports, so the exact stage-1 delay is not observable. The bench therefore accepts a stage-1 delay within a one-tick window. It measures the distance from the interrupt edge to the reset pulse exactly, because both events fall on tick edges. The hardest case to reach is the slow divide: one tick there costs 2^15 clocks. The bench covers it with zero preloads, so one full two-stage timeout fits in the run. The lock bit cannot be undone by software. The bench therefore tests it after all other scenarios and then applies power-on reset again before the slow-tick run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_ARMED = 2'd1,
    KEY_OPEN  = 2'd2
  } keyState_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic reload;
    logic enable;
    logic fastTick;
  } dpCtrl_t;

  // expiry events from datapath to control
  typedef struct packed {
    logic stage1Exp;
    logic stage2Exp;
  } dpEvt_t;

  localparam logic [2:0] IDX_PRE1   = 3'd0;
  localparam logic [2:0] IDX_PRE2   = 3'd1;
  localparam logic [2:0] IDX_STAT   = 3'd2;
  localparam logic [2:0] IDX_RELOAD = 3'd3;
  localparam logic [2:0] IDX_CTRL   = 3'd4;
  localparam logic [2:0] IDX_CFG    = 3'd5;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int PRELOAD_W     = 20,
  parameter int SLOW_DIV_LOG2 = 15,
  parameter int FAST_DIV_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctl,
  input  logic [PRELOAD_W-1:0] preload1,
  input  logic [PRELOAD_W-1:0] preload2,
  output dpEvt_t               evt
);

  logic [SLOW_DIV_LOG2-1:0] prescale;
  logic [PRELOAD_W-1:0]     count;
  logic                     stage;   // 0: stage 1, 1: stage 2
  logic                     tick;
  logic                     slowTick;
  logic                     fastTick;
  logic                     countZero;
  logic                     running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prescale <= '0;
    else       prescale <= prescale + 1'b1;
  end

  generate
    if (FAST_DIV_LOG2 < SLOW_DIV_LOG2) begin : g_twoRates
      assign fastTick = &prescale[FAST_DIV_LOG2-1:0];
    end else begin : g_oneRate
      assign fastTick = &prescale;
    end
  endgenerate

  assign slowTick  = &prescale;
  assign tick      = ctl.fastTick ? fastTick : slowTick;
  assign countZero = (count == '0);
  assign running   = ctl.enable && !ctl.reload;

  assign evt.stage1Exp = running && tick && countZero && !stage;
  assign evt.stage2Exp = running && tick && countZero && stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      stage <= 1'b0;
    end else if (!running) begin
      count <= preload1;
      stage <= 1'b0;
    end else if (tick) begin
      if (countZero) begin
        stage <= !stage;
        count <= stage ? preload1 : preload2;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !tick) |=> ($stable(count) && $stable(stage)));

  // R5
  stage_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stage) |-> $past(evt.stage1Exp));

  // R12
  idle_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.enable) |=> (!stage));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int PRELOAD_W = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [4:0]           busAddr,
  input  logic                 busWe,
  input  logic [3:0]           busBe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  dpEvt_t               evt,
  output dpCtrl_t              dpCtl,
  output logic [PRELOAD_W-1:0] preload1,
  output logic [PRELOAD_W-1:0] preload2,
  output logic                 irqOut,
  output logic                 rstOut
);

  keyState_e  keyState;
  logic [2:0] wordIdx;
  logic       isKey;
  logic       protHit;
  logic       granted;
  logic       reloadStb;
  logic       flagClr;
  logic       lockBit, enableBit, modeBit;
  logic       rstMask, fastSel;
  logic [1:0] irqType;
  logic       irqStat, timeoutFlag;
  logic       unusedAddr;

  function automatic logic [31:0] mergeBytes(logic [31:0] oldVal,
                                             logic [31:0] newVal,
                                             logic [3:0]  be);
    logic [31:0] mask;
    for (int b = 0; b < 4; b++) mask[b*8 +: 8] = {8{be[b]}};
    return (oldVal & ~mask) | (newVal & mask);
  endfunction

  assign unusedAddr = ^busAddr[1:0];
  assign wordIdx    = busAddr[4:2];
  assign isKey      = busWe && (wordIdx == IDX_RELOAD) && busBe[0] &&
                      ((busWdata[7:0] == KEY_FIRST) || (busWdata[7:0] == KEY_SECOND));
  assign protHit    = busWe && !isKey &&
                      ((wordIdx == IDX_PRE1) || (wordIdx == IDX_PRE2) || (wordIdx == IDX_RELOAD));
  assign granted    = protHit && (keyState == KEY_OPEN);
  assign reloadStb  = granted && (wordIdx == IDX_RELOAD) && busBe[1] && busWdata[8];
  assign flagClr    = granted && (wordIdx == IDX_RELOAD) && busBe[1] && busWdata[9];

  // key sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KEY_IDLE;
    else if (isKey) begin
      if (busWdata[7:0] == KEY_FIRST) keyState <= KEY_ARMED;
      else keyState <= (keyState == KEY_ARMED) ? KEY_OPEN : KEY_IDLE;
    end else if (protHit) keyState <= KEY_IDLE;
  end

  // guarded preloads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preload1 <= '0;
      preload2 <= '0;
    end else if (granted) begin
      if (wordIdx == IDX_PRE1)
        preload1 <= PRELOAD_W'(mergeBytes(32'(preload1), busWdata, busBe));
      if (wordIdx == IDX_PRE2)
        preload2 <= PRELOAD_W'(mergeBytes(32'(preload2), busWdata, busBe));
    end
  end

  // control and configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBit   <= 1'b0;
      enableBit <= 1'b0;
      modeBit   <= 1'b0;
      rstMask   <= 1'b0;
      fastSel   <= 1'b0;
      irqType   <= 2'b00;
    end else if (busWe && busBe[0]) begin
      if (wordIdx == IDX_CTRL) begin
        lockBit   <= lockBit | busWdata[0];
        enableBit <= busWdata[1] | (lockBit & enableBit);
        if (!lockBit) modeBit <= busWdata[2];
      end
      if (wordIdx == IDX_CFG) begin
        rstMask <= busWdata[5];
        fastSel <= busWdata[2];
        irqType <= busWdata[1:0];
      end
    end
  end

  // interrupt status, timeout flag, reset pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqStat     <= 1'b0;
      timeoutFlag <= 1'b0;
      rstOut      <= 1'b0;
    end else begin
      if (evt.stage1Exp && (irqType != 2'b11)) irqStat <= 1'b1;
      else if (busWe && busBe[0] && (wordIdx == IDX_STAT) && busWdata[0]) irqStat <= 1'b0;
      if (evt.stage2Exp && !modeBit) timeoutFlag <= 1'b1;
      else if (flagClr) timeoutFlag <= 1'b0;
      rstOut <= evt.stage2Exp && !modeBit && !rstMask;
    end
  end

  assign irqOut         = irqStat;
  assign dpCtl.reload   = reloadStb;
  assign dpCtl.enable   = enableBit;
  assign dpCtl.fastTick = fastSel;

  always_comb begin
    case (wordIdx)
      IDX_PRE1:   busRdata = 32'(preload1);
      IDX_PRE2:   busRdata = 32'(preload2);
      IDX_STAT:   busRdata = {31'b0, irqStat};
      IDX_RELOAD: busRdata = {22'b0, timeoutFlag, 9'b0};
      IDX_CTRL:   busRdata = {29'b0, modeBit, enableBit, lockBit};
      IDX_CFG:    busRdata = {26'b0, rstMask, 2'b0, fastSel, irqType};
      default:    busRdata = 32'b0;
    endcase
  end

  // R3
  preload_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(preload1) || !$stable(preload2)) |-> $past(keyState == KEY_OPEN));

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockBit |=> lockBit);

  // R7
  enable_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockBit && enableBit) |=> enableBit);

  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(evt.stage2Exp));

  // R8
  rst_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |-> ($past(evt.stage2Exp) && !$past(rstMask)));

endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog
  import wdt_pkg::*;
#(
  parameter int PRELOAD_W     = 20,
  parameter int SLOW_DIV_LOG2 = 15,
  parameter int FAST_DIV_LOG2 = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  busAddr,
  input  logic        busWe,
  input  logic [3:0]  busBe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irqOut,
  output logic        wdtRstOut
);

  dpCtrl_t              dpCtl;
  dpEvt_t               dpEvt;
  logic [PRELOAD_W-1:0] preload1;
  logic [PRELOAD_W-1:0] preload2;

  wdt_ctrl #(.PRELOAD_W(PRELOAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata),
    .evt(dpEvt), .dpCtl(dpCtl),
    .preload1(preload1), .preload2(preload2),
    .irqOut(irqOut), .rstOut(wdtRstOut)
  );

  wdt_datapath #(
    .PRELOAD_W(PRELOAD_W),
    .SLOW_DIV_LOG2(SLOW_DIV_LOG2),
    .FAST_DIV_LOG2(FAST_DIV_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl),
    .preload1(preload1), .preload2(preload2), .evt(dpEvt)
  );

endmodule

// File: tb/dual_stage_watchdog_test.sv
module dual_stage_watchdog_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, wdtRstOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_stage_watchdog uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .wdtRstOut(wdtRstOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    busAddr = a; busWdata = d; busBe = be; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic unlock();
    wr(5'h0C, 32'h80);
    wr(5'h0C, 32'h86);
  endtask

  task automatic restart();
    unlock();
    wr(5'h0C, 32'h100);
  endtask

  // which: 0 = interrupt, 1 = reset pulse
  task automatic waitSig(input int which, input int limit, output int cnt, output bit seen);
    cnt = 0; seen = 1'b0;
    while (cnt < limit) begin
      @(negedge clk);
      cnt++;
      if ((which == 0) ? irqOut : wdtRstOut) begin seen = 1'b1; break; end
    end
  endtask

  task automatic setup(input int p1, input int p2, input logic [31:0] cfg, input logic [31:0] ctl);
    wr(5'h10, 32'h0);
    wr(5'h08, 32'h1);
    unlock(); wr(5'h00, 32'(p1));
    unlock(); wr(5'h04, 32'(p2));
    unlock(); wr(5'h0C, 32'h200);
    wr(5'h14, cfg);
    wr(5'h10, ctl);
  endtask

  task automatic por();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    bit seen;
    bit sawOther;

    por();
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4), v);
      check("R1 reset value", v, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irqOut}, 32'h0);
    check("R1 reset pulse after reset", {31'b0, wdtRstOut}, 32'h0);

    // R2 guarded write without key
    wr(5'h00, 32'h12345);
    rd(5'h00, v); check("R2 write without key", v, 32'h0);
    // R3 key then one write, second ignored
    unlock(); wr(5'h00, 32'h5);
    rd(5'h00, v); check("R3 first write after key", v, 32'h5);
    wr(5'h00, 32'h7);
    rd(5'h00, v); check("R3 second write ignored", v, 32'h5);
    // R2 wrong order
    wr(5'h0C, 32'h86); wr(5'h0C, 32'h80); wr(5'h00, 32'h9);
    rd(5'h00, v); check("R2 reversed key", v, 32'h5);
    // R2 interrupted key
    wr(5'h0C, 32'h80); wr(5'h04, 32'h3); wr(5'h0C, 32'h86); wr(5'h04, 32'h4);
    rd(5'h04, v); check("R2 broken key", v, 32'h0);
    // R1 byte enables
    unlock(); wr(5'h00, 32'hABCDE, 4'b0001);
    rd(5'h00, v); check("R1 byte enable merge", v, 32'hDE);
    unlock(); wr(5'h04, 32'hFFFFFFFF);
    rd(5'h04, v); check("R1 preload width", v, 32'hFFFFF);

    // R5 sweep, fast tick, watchdog mode
    for (int p1 = 0; p1 < 3; p1++) begin
      for (int p2 = 0; p2 < 4; p2++) begin
        setup(p1, p2, 32'h04, 32'h2);
        waitSig(0, 200, n, seen);
        checks++;
        if (!seen || n < p1 * 32 + 1 || n > p1 * 32 + 32) begin
          errors++;
          $display("FAIL R5 stage1 delay p1=%0d actual=%0d expected=%0d..%0d",
                   p1, n, p1 * 32 + 1, p1 * 32 + 32);
        end
        waitSig(1, 300, n, seen);
        check("R5 stage2 delay", 32'(n), 32'((p2 + 1) * 32));
        @(negedge clk);
        check("R5 pulse width", {31'b0, wdtRstOut}, 32'h0);
        rd(5'h0C, v); check("R6 flag set", v, 32'h200);
        rd(5'h08, v); check("R9 status latched", v, 32'h1);
      end
    end

    // R6 flag clear rules
    wr(5'h10, 32'h0);
    wr(5'h0C, 32'h200);
    rd(5'h0C, v); check("R6 clear without key", v, 32'h200);
    unlock(); wr(5'h0C, 32'h200);
    rd(5'h0C, v); check("R6 clear with key", v, 32'h0);
    // R9 W1C
    wr(5'h08, 32'h1);
    check("R9 irq cleared", {31'b0, irqOut}, 32'h0);

    // R4 periodic restart keeps it quiet
    setup(2, 0, 32'h04, 32'h2);
    sawOther = 1'b0;
    for (int i = 0; i < 20; i++) begin
      repeat (20) begin @(negedge clk); if (irqOut) sawOther = 1'b1; end
      restart();
      if (irqOut) sawOther = 1'b1;
    end
    check("R4 no expiry while restarting", {31'b0, sawOther}, 32'h0);
    waitSig(0, 200, n, seen);
    checks++;
    if (!seen || n < 65 || n > 96) begin
      errors++;
      $display("FAIL R4 delay after last restart actual=%0d expected=65..96", n);
    end

    // R8 reset masked
    setup(0, 0, 32'h24, 32'h2);
    waitSig(0, 100, n, seen);
    check("R8 irq still raised", {31'b0, seen}, 32'h1);
    waitSig(1, 200, n, seen);
    check("R8 no reset pulse", {31'b0, seen}, 32'h0);
    rd(5'h0C, v); check("R8 flag still set", v, 32'h200);

    // R9 interrupt type 11
    setup(0, 0, 32'h07, 32'h2);
    sawOther = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irqOut) sawOther = 1'b1;
      if (wdtRstOut) seen = 1'b1;
    end
    check("R9 type 11 no irq", {31'b0, sawOther}, 32'h0);
    check("R9 type 11 reset still fires", {31'b0, seen}, 32'h1);
    rd(5'h08, v); check("R9 type 11 status clear", v, 32'h0);

    // R11 timer mode
    setup(0, 0, 32'h04, 32'h6);
    waitSig(0, 100, n, seen);
    check("R11 irq in timer mode", {31'b0, seen}, 32'h1);
    waitSig(1, 200, n, seen);
    check("R11 no reset pulse", {31'b0, seen}, 32'h0);
    rd(5'h0C, v); check("R11 no flag", v, 32'h0);

    // R12 disabled
    setup(0, 0, 32'h04, 32'h0);
    waitSig(0, 500, n, seen);
    check("R12 disabled no irq", {31'b0, seen}, 32'h0);

    // R7 lock
    setup(3, 3, 32'h04, 32'h3);
    rd(5'h10, v); check("R7 lock and enable", v, 32'h3);
    wr(5'h10, 32'h0);
    rd(5'h10, v); check("R7 disable refused", v, 32'h3);
    wr(5'h10, 32'h4);
    rd(5'h10, v); check("R7 mode frozen", v, 32'h3);
    waitSig(0, 300, n, seen);
    check("R7 still counting", {31'b0, seen}, 32'h1);
    waitSig(1, 300, n, seen);
    check("R7 reset pulse does not clear lock", {31'b0, seen}, 32'h1);
    @(negedge clk);
    rd(5'h10, v); check("R7 lock after pulse", v, 32'h3);
    por();
    rd(5'h10, v); check("R7 cleared by power-on reset", v, 32'h0);
    rd(5'h0C, v); check("R6 flag cleared by power-on reset", v, 32'h0);

    // R10 slow tick
    setup(0, 0, 32'h00, 32'h2);
    waitSig(0, 33000, n, seen);
    checks++;
    if (!seen || n > 32768) begin
      errors++;
      $display("FAIL R10 slow stage1 actual=%0d expected=1..32768", n);
    end
    waitSig(1, 33000, n, seen);
    check("R10 slow stage2 period", 32'(n), 32'd32768);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule